// File: doc/BRIEF.md
# Serial Packet End-Around Checksum

This block computes and checks the 16-bit checksum of a byte-serial tape packet. Bytes come in one per cycle, each qualified by a valid strobe. A start strobe marks the first byte of a packet and an end strobe marks the last byte that is summed. The summed bytes are the two header bytes followed by the message bytes. They are paired into little-endian 16-bit words and added with end-around carry. An odd last byte is zero-extended before it is added.

The two bytes that follow the end-marked byte are the received checksum, low byte first. They are not summed. Instead they are compared with the running sum. The same block serves the transmit side and the receive side. A transmitter reads the sum on `csum_o` once `done_o` rises. A receiver uses `match_o` and a saturating mismatch counter. A mismatch never cuts a packet short: the block still completes the packet and raises `done_o`.

Top module: `tape_pkt_csum`

## Requirements
- R1: The first summed byte of a packet is bits 7:0 of the first word and the second is bits 15:8. Every later pair is packed the same way. The end strobe may sit on the second header byte, which gives a packet with no message bytes.
- R2: Each word is added modulo 2^16, and a carry out of bit 15 is added back into bit 0. Adding a nonzero word therefore never leaves a zero sum.
- R3: When the number of summed bytes is odd, the final byte is added as {8'h00, byte}.
- R4: The two valid bytes after the end-marked byte are taken as the received checksum, with the first byte as bits 7:0 and the second as bits 15:8. Neither byte changes `csum_o`.
- R5: `match_o` is 1 when the received checksum equals the computed sum and 0 otherwise. The packet completes with `done_o` in both cases.
- R6: A valid byte with the start strobe clears the sum and the pairing phase in the same cycle and is taken as the first header byte. This holds even in the middle of a packet or during its checksum bytes.
- R7: Cycles with valid low are ignored, as are valid bytes that arrive outside a packet (after reset or after completion) without the start strobe. They leave `csum_o`, `done_o`, `match_o` and the counter unchanged.
- R8: `done_o` and `match_o` are updated one cycle after the second checksum byte is accepted. They hold until the next start strobe is accepted, which clears `done_o` at the following edge.
- R9: `err_cnt_o` rises by one for each completed packet whose checksum mismatches and stays at its maximum (255 by default).
- R10: After reset, `csum_o`, `done_o`, `match_o` and `err_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_sop | input | 1 | With `in_valid`: first byte of a new packet |
| in_eod | input | 1 | With `in_valid`: last byte included in the sum |
| in_byte | input | 8 | Packet byte |
| csum_o | output | 16 | Running and final end-around sum |
| done_o | output | 1 | Checksum comparison result is present |
| match_o | output | 1 | Received checksum equaled the sum |
| err_cnt_o | output | ERR_CNT_W | Saturating count of mismatching packets |

## Verification
The bench sweeps every message length from zero to twelve bytes with good and corrupted checksums. This exercises both parities of the final byte. A design that dropped the lone byte or shifted it into the high half would miss only on the odd lengths. Runs of 0xFF bytes force a carry on nearly every add, so a design that drops the end-around carry shows a sum off by the number of carries. The bench also restarts packets partway through the body and partway through the checksum bytes. It feeds stray bytes and idle gaps, then drives more than 255 bad packets. These catch, in turn: a stale pairing phase, checksum bytes leaking into the sum, stray bytes shifting the result, and a counter that wraps to zero.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_CKLO = 2'd2,
    ST_CKHI = 2'd3
  } tpc_state_e;

  // Add two words; a carry out of the top bit re-enters at bit 0.
  function automatic logic [WORD_W-1:0] eac_add(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
  endfunction

  // Little-endian packing: first byte low, second byte high.
  function automatic logic [WORD_W-1:0] join_le(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/tpc_frame_ctl.sv
module tpc_frame_ctl
  import tpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic sop,
  input  logic eod,
  output logic restart,
  output logic body_take,
  output logic cklo_take,
  output logic ckhi_take
);

  tpc_state_e state_q, state_d;

  always_comb begin
    restart   = valid & sop;
    body_take = valid & (sop | (state_q == ST_BODY));
    cklo_take = valid & ~sop & (state_q == ST_CKLO);
    ckhi_take = valid & ~sop & (state_q == ST_CKHI);
  end

  always_comb begin
    state_d = state_q;
    if (restart)                state_d = eod ? ST_CKLO : ST_BODY;
    else if (body_take && eod)  state_d = ST_CKLO;
    else if (cklo_take)         state_d = ST_CKHI;
    else if (ckhi_take)         state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R4: a byte is either summed or a checksum byte, never both
  assert_one_role_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({body_take, cklo_take, ckhi_take}));

  // R4: the end-marked byte is followed by the low checksum byte slot
  assert_eod_to_cklo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (body_take && eod) |=> (state_q == ST_CKLO));

endmodule

// File: rtl/tpc_pair.sv
module tpc_pair
  import tpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic              eod,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  logic              hi_phase_q;
  logic [BYTE_W-1:0] lo_q;
  logic              eff_hi;

  always_comb begin
    eff_hi     = restart ? 1'b0 : hi_phase_q;
    word_valid = take & (eff_hi | eod);
    word       = eff_hi ? join_le(lo_q, byte_in) : join_le(byte_in, '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_phase_q <= 1'b0;
      lo_q       <= '0;
    end else if (take) begin
      if (word_valid) begin
        hi_phase_q <= 1'b0;
      end else begin
        hi_phase_q <= 1'b1;
        lo_q       <= byte_in;
      end
    end
  end

  // R6: a start byte always lands in the low half of a fresh pair
  assert_start_low_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && restart && !eod) |=> hi_phase_q);

  // R3: the last summed byte is always flushed into the sum
  assert_tail_flushed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && eod) |-> word_valid);

endmodule

// File: rtl/tpc_accum.sv
module tpc_accum
  import tpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] acc
);

  logic [WORD_W-1:0] acc_q, base, acc_d;

  always_comb begin
    base  = restart ? '0 : acc_q;
    acc_d = word_valid ? eac_add(base, word) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R6: a start byte that completes no word leaves a cleared sum
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !word_valid) |=> (acc_q == '0));

  // R2: with the carry wrapped back, a nonzero addend never yields zero
  assert_eac_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && (word != '0)) |=> (acc_q != '0));

endmodule

// File: rtl/tpc_verify.sv
module tpc_verify
  import tpc_pkg::*;
#(
  parameter int ERR_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 cklo_take,
  input  logic                 ckhi_take,
  input  logic [BYTE_W-1:0]    byte_in,
  input  logic [WORD_W-1:0]    acc,
  output logic                 done,
  output logic                 match,
  output logic [ERR_CNT_W-1:0] err_cnt
);

  localparam logic [ERR_CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ERR_CNT_W-1:0] CNT_ONE = ERR_CNT_W'(1);

  logic [BYTE_W-1:0]    rx_lo_q;
  logic                 done_q, match_q;
  logic [ERR_CNT_W-1:0] cnt_q;
  logic                 hit;

  assign hit = (join_le(rx_lo_q, byte_in) == acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lo_q <= '0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (restart) begin
        done_q  <= 1'b0;
        match_q <= 1'b0;
      end
      if (cklo_take) rx_lo_q <= byte_in;
      if (ckhi_take) begin
        done_q  <= 1'b1;
        match_q <= hit;
        if (!hit && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + CNT_ONE;
      end
    end
  end

  assign done    = done_q;
  assign match   = match_q;
  assign err_cnt = cnt_q;

  // R8: the result is posted one cycle after the second checksum byte
  assert_done_after_ckhi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ckhi_take |=> done_q);

  // R8: the result holds until a start byte is accepted
  assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !restart) |=> (done_q && $stable(match_q)));

  // R9: each mismatch below the ceiling adds exactly one
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ckhi_take && !hit && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R9: the counter never wraps past its ceiling
  assert_cnt_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R5: a reported mismatch is always reflected in the counter
  assert_miss_counted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && !match_q) |-> (cnt_q != '0));

endmodule

// File: rtl/tape_pkt_csum.sv
module tape_pkt_csum
  import tpc_pkg::*;
#(
  parameter int ERR_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic                 in_eod,
  input  logic [7:0]           in_byte,
  output logic [15:0]          csum_o,
  output logic                 done_o,
  output logic                 match_o,
  output logic [ERR_CNT_W-1:0] err_cnt_o
);

  logic              restart, body_take, cklo_take, ckhi_take;
  logic              word_valid;
  logic [WORD_W-1:0] word, acc;

  tpc_frame_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (in_valid),
    .sop       (in_sop),
    .eod       (in_eod),
    .restart   (restart),
    .body_take (body_take),
    .cklo_take (cklo_take),
    .ckhi_take (ckhi_take)
  );

  tpc_pair u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (body_take),
    .restart    (restart),
    .eod        (in_eod),
    .byte_in    (in_byte),
    .word_valid (word_valid),
    .word       (word)
  );

  tpc_accum u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .word_valid (word_valid),
    .word       (word),
    .acc        (acc)
  );

  tpc_verify #(.ERR_CNT_W(ERR_CNT_W)) u_ver (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .cklo_take (cklo_take),
    .ckhi_take (ckhi_take),
    .byte_in   (in_byte),
    .acc       (acc),
    .done      (done_o),
    .match     (match_o),
    .err_cnt   (err_cnt_o)
  );

  assign csum_o = acc;

  // R4: checksum bytes never move the sum
  assert_ck_not_summed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cklo_take || ckhi_take) |=> $stable(csum_o));

  // R7: idle cycles change none of the outputs
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(csum_o) && $stable(done_o) && $stable(err_cnt_o)));

endmodule

// File: tb/tape_pkt_csum_tb.sv
`timescale 1ns/1ps
module tape_pkt_csum_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eod = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [15:0] csum_o;
  logic       done_o, match_o;
  logic [7:0] err_cnt_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  exp_cnt = 0;
  bit  finished = 0;
  logic [7:0] pb [0:63];

  tape_pkt_csum u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eod(in_eod), .in_byte(in_byte), .csum_o(csum_o), .done_o(done_o),
    .match_o(match_o), .err_cnt_o(err_cnt_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Whole-packet sum folded afterwards; equals per-word end-around addition.
  function automatic int ref_sum(input int nbytes);
    int unsigned total = 0;
    for (int i = 0; i < nbytes; i += 2) begin
      int unsigned w = pb[i];
      if (i + 1 < nbytes) w += pb[i+1] * 256;
      total += w;
    end
    while (total > 32'hFFFF) total = (total & 32'hFFFF) + (total >> 16);
    return int'(total);
  endfunction

  task automatic fill(input int seed, input int nmsg);
    pb[0] = 8'h02;
    pb[1] = 8'(nmsg);
    for (int i = 2; i < 64; i++) pb[i] = 8'(seed * 73 + i * 29 + i * i * 5);
  endtask

  task automatic drive(input logic [7:0] b, input bit sop, input bit eod);
    @(negedge clk);
    in_valid = 1'b1; in_sop = sop; in_eod = eod; in_byte = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eod = 1'b0;
    end
  endtask

  task automatic send_body(input int nbytes, input int gap);
    for (int i = 0; i < nbytes; i++) begin
      drive(pb[i], i == 0, i == nbytes - 1);
      if (gap > 0 && (i % 3) == 1) idle(gap);
    end
  endtask

  task automatic send_pkt(input int nbytes, input bit corrupt, input int gap, input string tag);
    int sum, ck;
    send_body(nbytes, gap);
    sum = ref_sum(nbytes);
    ck  = corrupt ? (sum ^ 16'h0100) : sum;
    drive(8'(ck), 1'b0, 1'b0);
    drive(8'(ck >> 8), 1'b0, 1'b0);
    idle(1);
    if (corrupt && exp_cnt < 255) exp_cnt++;
    check(done_o == 1'b1, {tag, " R8 done"}, int'(done_o), 1);
    check(int'(csum_o) == sum, {tag, " sum"}, int'(csum_o), sum);
    check(match_o == !corrupt, {tag, " R5 match"}, int'(match_o), int'(!corrupt));
    check(int'(err_cnt_o) == exp_cnt, {tag, " R9 count"}, int'(err_cnt_o), exp_cnt);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R10
    check(csum_o == 16'h0 && done_o == 1'b0 && match_o == 1'b0 && err_cnt_o == 8'h0,
          "R10 reset state", int'({done_o, match_o, csum_o}), 0);

    // R7: bytes before any start are ignored
    drive(8'hA5, 1'b0, 1'b0); drive(8'h3C, 1'b0, 1'b1); idle(1);
    check(csum_o == 16'h0 && done_o == 1'b0, "R7 stray before start", int'(csum_o), 0);

    // R1 R3 R4 R5: sweep of message lengths, good and bad checksums
    for (int n = 0; n <= 12; n++) begin
      fill(n + 1, n);
      send_pkt(n + 2, 1'b0, 0, "R1 R3 R4 good");
      fill(n + 7, n);
      send_pkt(n + 2, 1'b1, 0, "R5 bad");
    end

    // R2: all-ones payload forces carries on almost every add
    for (int n = 7; n <= 8; n++) begin
      fill(0, n);
      for (int i = 0; i < n + 2; i++) pb[i] = 8'hFF;
      send_pkt(n + 2, 1'b0, 0, "R2 carries");
    end

    // R7: idle gaps inside a packet
    fill(5, 9);
    send_pkt(11, 1'b0, 2, "R7 gaps");

    // R7 R8: stray bytes after completion change nothing
    s0 = int'(csum_o);
    drive(8'h11, 1'b0, 1'b0); drive(8'h22, 1'b0, 1'b1); drive(8'h33, 1'b0, 1'b0); idle(1);
    check(done_o == 1'b1 && match_o == 1'b1, "R8 hold after stray", int'({done_o, match_o}), 3);
    check(int'(csum_o) == s0, "R7 stray after done", int'(csum_o), s0);
    check(int'(err_cnt_o) == exp_cnt, "R7 count untouched", int'(err_cnt_o), exp_cnt);

    // R6: restart in the middle of the body
    fill(40, 6);
    drive(8'h77, 1'b1, 1'b0); drive(8'h99, 1'b0, 1'b0); drive(8'h55, 1'b0, 1'b0);
    idle(1);
    check(done_o == 1'b0, "R8 start clears done", int'(done_o), 0);
    send_pkt(8, 1'b0, 0, "R6 restart mid body");

    // R6: restart after the low checksum byte
    fill(41, 5);
    send_body(7, 0);
    drive(8'hEE, 1'b0, 1'b0);
    fill(42, 3);
    send_pkt(5, 1'b0, 0, "R6 restart in checksum");

    // R9: drive the counter to its ceiling and past it
    for (int k = 0; k < 260; k++) begin
      fill(k, 0);
      send_pkt(2, 1'b1, 0, "R9 saturation");
    end
    check(err_cnt_o == 8'd255, "R9 ceiling", int'(err_cnt_o), 255);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule